// File: doc/BRIEF.md
# Serial EEPROM image loader

This block fetches a 64-word, 16-bit image from a three-wire serial EEPROM and turns it into a 48-bit station address. It drives the memory's select, shift clock and serial input pins, and listens on the serial output pin. A load starts by itself when reset is released. A later load starts when the `start` pin is pulsed while the block is idle.

The EEPROM's address width is not fixed in advance. The block reads word 0 with a six-bit address. An all-ones answer means a wider, eight-bit part is attached, and all later reads use the wide address. It then reads the whole image in ascending order and keeps a running 16-bit sum of the words. The station address is published only when that sum matches a fixed signature. Otherwise the address output is zero.

`load_done` pulses for one cycle when the result appears. `image_valid` and `station_addr` then hold until the next accepted start. The serial clock half-period is `CLK_DIV` cycles of `clk`.

Top module: `mw_eeprom_loader`

## Requirements
- R1: A load starts on the first cycle after reset is released. A `start` pulse while idle starts another load. A `start` pulse during a load is ignored: the running load still makes exactly 65 accesses and gives exactly one `load_done`.
- R2: Every access begins with `rom_cs` low for at least one half-period, then raises it. `rom_cs` is low again when the access ends. `rom_sck` is high only while `rom_cs` is high.
- R3: The command is a 13-bit frame sent most significant bit first. It is zeros at the top, then the bits 1,1,0, then the word address MSB first. `rom_si` changes only while `rom_sck` is low. Each bit spends exactly `CLK_DIV` cycles with `rom_sck` low and then `CLK_DIV` cycles with it high.
- R4: After the command, 16 data bits are read MSB first. Each bit is sampled from `rom_so` in the last `clk` cycle of a `rom_sck` high half-period.
- R5: The first access of a load reads word 0 with a 6-bit address. If that read returns 0xFFFF, all later accesses use an 8-bit address. Any other value, including 0xFFFE, keeps the 6-bit address.
- R6: After the probe, words 0 to 63 are read in ascending order, so a load makes 65 accesses in total.
- R7: The 64 words are summed modulo 2^16. `image_valid` is 1 exactly when the sum equals 0xBABA.
- R8: With a valid image, the address bytes come from words 0, 1 and 2, low byte before high byte. So `station_addr[47:40]` is word0[7:0], `[39:32]` is word0[15:8], `[31:24]` is word1[7:0], and so on down to `[7:0]` = word2[15:8]. With an invalid image, `station_addr` is all zeros.
- R9: `load_done` is a one-cycle pulse. In the same cycle, `image_valid` and `station_addr` take their new values, and they hold them until a start is accepted. An accepted start clears both to zero one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse to begin a new load when idle |
| rom_cs | output | 1 | EEPROM chip select, active high |
| rom_sck | output | 1 | EEPROM shift clock |
| rom_si | output | 1 | Serial data into the EEPROM |
| rom_so | input | 1 | Serial data out of the EEPROM |
| station_addr | output | 48 | Station address assembled from words 0 to 2, zero when the image is invalid |
| image_valid | output | 1 | Checksum of the last load matched |
| load_done | output | 1 | One-cycle pulse when a load completes |

## Verification
The bench builds the block with `CLK_DIV` = 2 and all other parameters at their defaults. This keeps one 65-access load near 8,300 cycles, so six complete loads fit in one run. The loads sweep both EEPROM address widths, with images built arithmetically, each with a passing and a failing checksum. They also cover a word 0 of 0xFFFE, which sits one code away from the width switch, and a start pulse that arrives mid-load. A behavioural EEPROM model logs every address it decodes and whether its command was misframed. This lets the probe read, the word order and the serial timing all be compared against the requirements.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

  // One EEPROM access, one state per half-period of the serial clock.
  typedef enum logic [3:0] {
    SH_IDLE,
    SH_DESEL,
    SH_SEL,
    SH_CMD_LO,
    SH_CMD_HI,
    SH_GAP,
    SH_DAT_HI,
    SH_DAT_LO,
    SH_END
  } shift_state_e;

  // Whole-image load sequencing.
  typedef enum logic [2:0] {
    LD_BOOT,
    LD_IDLE,
    LD_PROBE_REQ,
    LD_PROBE_WAIT,
    LD_WORD_REQ,
    LD_WORD_WAIT,
    LD_FINISH
  } load_state_e;

  // Start bit plus read opcode, sent in front of the address.
  localparam logic [2:0] READ_OPCODE = 3'b110;

endpackage

// File: rtl/mw_half_timer.sv
module mw_half_timer #(
  parameter int unsigned HALF_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int unsigned CNT_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // The tick marks the last cycle of each half-period.
  assign tick = run && (cnt == LAST);

  // R3: the half-period counter never runs past its limit.
  a_r3_half_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

endmodule

// File: rtl/mw_word_shifter.sv
module mw_word_shifter
  import mw_eeprom_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4,
  parameter int unsigned FRAME_W = 13,
  parameter int unsigned WORD_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic [FRAME_W-1:0] frame,
  input  logic               rom_so,
  output logic               rom_cs,
  output logic               rom_sck,
  output logic               rom_si,
  output logic               word_done,
  output logic [WORD_W-1:0]  word_q
);

  localparam int unsigned MAX_BITS = (FRAME_W > WORD_W) ? FRAME_W : WORD_W;
  localparam int unsigned IDX_W    = $clog2(MAX_BITS);
  localparam logic [IDX_W-1:0] CMD_LAST = IDX_W'(FRAME_W - 1);
  localparam logic [IDX_W-1:0] DAT_LAST = IDX_W'(WORD_W - 1);

  shift_state_e       st;
  logic [FRAME_W-1:0] cmd_sh;
  logic [IDX_W-1:0]   bit_idx;
  logic               half_tick;
  logic               timer_run;

  assign timer_run = (st != SH_IDLE);

  mw_half_timer #(
    .HALF_CYCLES(CLK_DIV)
  ) u_half_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (timer_run),
    .tick (half_tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= SH_IDLE;
      cmd_sh    <= '0;
      bit_idx   <= '0;
      word_q    <= '0;
      word_done <= 1'b0;
    end else begin
      word_done <= 1'b0;
      if (st == SH_IDLE) begin
        if (req) begin
          st      <= SH_DESEL;
          cmd_sh  <= frame;
          bit_idx <= '0;
        end
      end else if (half_tick) begin
        case (st)
          SH_DESEL:  st <= SH_SEL;
          SH_SEL:    st <= SH_CMD_LO;
          SH_CMD_LO: st <= SH_CMD_HI;
          SH_CMD_HI: begin
            if (bit_idx == CMD_LAST) begin
              st      <= SH_GAP;
              bit_idx <= '0;
            end else begin
              st      <= SH_CMD_LO;
              bit_idx <= bit_idx + IDX_W'(1);
              cmd_sh  <= {cmd_sh[FRAME_W-2:0], 1'b0};
            end
          end
          SH_GAP:    st <= SH_DAT_HI;
          SH_DAT_HI: begin
            word_q <= {word_q[WORD_W-2:0], rom_so};
            st     <= SH_DAT_LO;
          end
          SH_DAT_LO: begin
            if (bit_idx == DAT_LAST) begin
              st <= SH_END;
            end else begin
              st      <= SH_DAT_HI;
              bit_idx <= bit_idx + IDX_W'(1);
            end
          end
          SH_END: begin
            st        <= SH_IDLE;
            word_done <= 1'b1;
          end
          default: st <= SH_IDLE;
        endcase
      end
    end
  end

  // Pin levels decoded straight from the state register.
  assign rom_cs  = (st == SH_SEL) || (st == SH_CMD_LO) || (st == SH_CMD_HI) ||
                   (st == SH_GAP) || (st == SH_DAT_HI) || (st == SH_DAT_LO);
  assign rom_sck = (st == SH_CMD_HI) || (st == SH_DAT_HI);
  assign rom_si  = ((st == SH_CMD_LO) || (st == SH_CMD_HI)) && cmd_sh[FRAME_W-1];

  // R2: the shift clock only toggles inside a selected access.
  a_r2_sck_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sck |-> rom_cs);

  // R2: the EEPROM is deselected when an access reports completion.
  a_r2_deselect_at_word_end: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> !rom_cs);

  // R3: serial input holds still for the whole high half-period.
  a_r3_si_steady_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_sck && $past(rom_sck)) |-> $stable(rom_si));

endmodule

// File: rtl/mw_load_seq.sv
module mw_load_seq
  import mw_eeprom_pkg::*;
#(
  parameter int unsigned NUM_WORDS   = 64,
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned SHORT_AW    = 6,
  parameter int unsigned LONG_AW     = 8,
  parameter int unsigned FRAME_W     = 13,
  parameter int unsigned ADDR_WORDS  = 3,
  parameter logic [WORD_W-1:0] CHECK_VALUE = 16'hBABA
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         word_done,
  input  logic [WORD_W-1:0]            word_q,
  output logic                         rd_req,
  output logic [FRAME_W-1:0]           rd_frame,
  output logic [ADDR_WORDS*WORD_W-1:0] station_addr,
  output logic                         image_valid,
  output logic                         load_done
);

  localparam int unsigned IDX_W  = $clog2(NUM_WORDS);
  localparam int unsigned ADDR_W = ADDR_WORDS * WORD_W;
  localparam int unsigned BYTE_W = WORD_W / 2;
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NUM_WORDS - 1);
  localparam logic [WORD_W-1:0] ALL_ONES = '1;

  load_state_e        st;
  logic               wide_aw;
  logic [IDX_W-1:0]   widx;
  logic [WORD_W-1:0]  sum;
  logic [WORD_W-1:0]  id_word [ADDR_WORDS];
  logic [ADDR_W-1:0]  id_swapped;
  logic [FRAME_W-1:0] frame_short;
  logic [FRAME_W-1:0] frame_long;
  logic               launch;

  // Byte order on the station address: low byte of each word first.
  generate
    for (genvar g = 0; g < ADDR_WORDS; g++) begin : g_swap
      assign id_swapped[ADDR_W-1-g*WORD_W -: WORD_W] =
        {id_word[g][BYTE_W-1:0], id_word[g][WORD_W-1:BYTE_W]};
    end
  endgenerate

  // Fixed-length frame: zero padding, opcode, then the address.
  assign frame_short = FRAME_W'({READ_OPCODE, SHORT_AW'(widx)});
  assign frame_long  = FRAME_W'({READ_OPCODE, LONG_AW'(widx)});
  assign rd_frame    = wide_aw ? frame_long : frame_short;
  assign rd_req      = (st == LD_PROBE_REQ) || (st == LD_WORD_REQ);
  assign launch      = (st == LD_BOOT) || ((st == LD_IDLE) && start);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= LD_BOOT;
      wide_aw      <= 1'b0;
      widx         <= '0;
      sum          <= '0;
      station_addr <= '0;
      image_valid  <= 1'b0;
      load_done    <= 1'b0;
      for (int k = 0; k < ADDR_WORDS; k++) id_word[k] <= '0;
    end else begin
      load_done <= 1'b0;
      if (launch) begin
        st           <= LD_PROBE_REQ;
        wide_aw      <= 1'b0;
        widx         <= '0;
        sum          <= '0;
        image_valid  <= 1'b0;
        station_addr <= '0;
      end else begin
        case (st)
          LD_PROBE_REQ: st <= LD_PROBE_WAIT;
          LD_PROBE_WAIT: begin
            if (word_done) begin
              wide_aw <= (word_q == ALL_ONES);
              st      <= LD_WORD_REQ;
            end
          end
          LD_WORD_REQ: st <= LD_WORD_WAIT;
          LD_WORD_WAIT: begin
            if (word_done) begin
              sum <= sum + word_q;
              for (int k = 0; k < ADDR_WORDS; k++) begin
                if (widx == IDX_W'(k)) id_word[k] <= word_q;
              end
              if (widx == LAST_IDX) begin
                st <= LD_FINISH;
              end else begin
                widx <= widx + IDX_W'(1);
                st   <= LD_WORD_REQ;
              end
            end
          end
          LD_FINISH: begin
            image_valid  <= (sum == CHECK_VALUE);
            station_addr <= (sum == CHECK_VALUE) ? id_swapped : '0;
            load_done    <= 1'b1;
            st           <= LD_IDLE;
          end
          default: st <= LD_IDLE;
        endcase
      end
    end
  end

  // R8: an invalid image never shows a non-zero address.
  a_r8_zero_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    !image_valid |-> (station_addr == '0));

  // R9: the completion strobe lasts one cycle.
  a_r9_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> !load_done);

  // R9: results only move with the strobe or after a start request.
  a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (load_done || ($stable(image_valid) && $stable(station_addr))));

endmodule

// File: rtl/mw_eeprom_loader.sv
module mw_eeprom_loader #(
  parameter int unsigned CLK_DIV    = 4,
  parameter int unsigned NUM_WORDS  = 64,
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned SHORT_AW   = 6,
  parameter int unsigned LONG_AW    = 8,
  parameter int unsigned FRAME_W    = 13,
  parameter int unsigned ADDR_WORDS = 3,
  parameter logic [WORD_W-1:0] CHECK_VALUE = 16'hBABA
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  output logic                         rom_cs,
  output logic                         rom_sck,
  output logic                         rom_si,
  input  logic                         rom_so,
  output logic [ADDR_WORDS*WORD_W-1:0] station_addr,
  output logic                         image_valid,
  output logic                         load_done
);

  logic               rd_req;
  logic [FRAME_W-1:0] rd_frame;
  logic               word_done;
  logic [WORD_W-1:0]  word_q;

  mw_word_shifter #(
    .CLK_DIV(CLK_DIV),
    .FRAME_W(FRAME_W),
    .WORD_W (WORD_W)
  ) u_shifter (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (rd_req),
    .frame    (rd_frame),
    .rom_so   (rom_so),
    .rom_cs   (rom_cs),
    .rom_sck  (rom_sck),
    .rom_si   (rom_si),
    .word_done(word_done),
    .word_q   (word_q)
  );

  mw_load_seq #(
    .NUM_WORDS  (NUM_WORDS),
    .WORD_W     (WORD_W),
    .SHORT_AW   (SHORT_AW),
    .LONG_AW    (LONG_AW),
    .FRAME_W    (FRAME_W),
    .ADDR_WORDS (ADDR_WORDS),
    .CHECK_VALUE(CHECK_VALUE)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .word_done   (word_done),
    .word_q      (word_q),
    .rd_req      (rd_req),
    .rd_frame    (rd_frame),
    .station_addr(station_addr),
    .image_valid (image_valid),
    .load_done   (load_done)
  );

endmodule

// File: tb/mw_eeprom_loader_tb.sv
module mw_eeprom_loader_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 2;
  localparam int FRAME_BITS = 13;
  localparam int ACCESSES   = 65;
  localparam int LOAD_LIMIT = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic rom_cs, rom_sck, rom_si;
  wire  rom_so;
  logic [47:0] station_addr;
  logic image_valid, load_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  mw_eeprom_loader #(.CLK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .rom_cs(rom_cs), .rom_sck(rom_sck), .rom_si(rom_si), .rom_so(rom_so),
    .station_addr(station_addr), .image_valid(image_valid), .load_done(load_done)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // ---------------- EEPROM model ----------------
  logic [15:0] mem [256];
  int dev_aw = 6;
  logic do_r = 1'b1;
  assign rom_so = rom_cs ? do_r : 1'b1;

  int rise_n, got_n, log_n, opcode_err, m_addr, m_op;
  bit started, data_ph, misframed;
  logic [9:0] cmd_acc;
  logic [15:0] out_sh;
  int log_addr [128];
  bit log_mis [128];

  always @(posedge rom_cs) begin
    rise_n = 0; started = 0; got_n = 0; data_ph = 0; misframed = 0; do_r = 1'b1;
  end

  always @(posedge rom_sck) begin
    if (rom_cs) begin
      rise_n++;
      if (data_ph) begin
        if (misframed) do_r = 1'b1;
        else begin
          do_r = out_sh[15];
          out_sh = {out_sh[14:0], 1'b0};
        end
      end else if (!started) begin
        if (rom_si) begin started = 1; got_n = 0; cmd_acc = '0; end
      end else begin
        cmd_acc = {cmd_acc[8:0], rom_si};
        got_n++;
        if (got_n == 2 + dev_aw) begin
          m_addr = int'(cmd_acc) & ((1 << dev_aw) - 1);
          m_op = (int'(cmd_acc) >> dev_aw) & 3;
          if (m_op != 2) opcode_err++;
          data_ph = 1;
          misframed = (rise_n > FRAME_BITS);
          out_sh = mem[m_addr];
          do_r = misframed;
          if (log_n < 128) begin log_addr[log_n] = m_addr; log_mis[log_n] = misframed; end
          log_n++;
        end
      end
    end
  end

  // ---------------- pin monitors ----------------
  int sk_run = 0, cs_low_run = 0, sk_err = 0, si_err = 0, cs_err = 0, done_cnt = 0;
  logic prev_sk = 1'b0, prev_si = 1'b0, prev_cs = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (load_done) done_cnt++;
      if (rom_sck) sk_run++;
      else begin
        if (prev_sk && sk_run != DIV) sk_err++;
        sk_run = 0;
      end
      if (rom_sck && prev_sk && rom_si != prev_si) si_err++;
      if (rom_sck && !rom_cs) cs_err++;
      if (rom_cs) begin
        if (!prev_cs && cs_low_run < DIV) cs_err++;
        cs_low_run = 0;
      end else cs_low_run++;
    end
    prev_sk = rom_sck; prev_si = rom_si; prev_cs = rom_cs;
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic fill(input int aw, input int mul, input int add, input bit good);
    logic [15:0] s;
    s = '0;
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * mul + add) ^ 16'(i << 9);
    for (int i = 0; i < 63; i++) s = s + mem[i];
    mem[63] = 16'hBABA - s + (good ? 16'd0 : 16'd1);
    dev_aw = aw;
  endtask

  function automatic logic [47:0] exp_addr();
    return {mem[0][7:0], mem[0][15:8], mem[1][7:0], mem[1][15:8], mem[2][7:0], mem[2][15:8]};
  endfunction

  task automatic clear_logs();
    @(posedge clk);
    log_n = 0; opcode_err = 0; done_cnt = 0; sk_err = 0; si_err = 0; cs_err = 0;
  endtask

  task automatic finish_load(input string name, input int aw, input bit good);
    int waited;
    logic [47:0] exp;
    int order_err;
    int mis_err;
    bit v_hold;
    logic [47:0] a_hold;
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (!load_done && waited < LOAD_LIMIT);
    check(load_done, {name, " R1 load completes"}, 64'(waited), 64'(LOAD_LIMIT));
    exp = good ? exp_addr() : 48'h0;
    check(image_valid == good, {name, " R7 checksum verdict"}, 64'(image_valid), 64'(good));
    check(station_addr == exp, {name, " R8 R4 station address"}, 64'(station_addr), 64'(exp));
    v_hold = image_valid;
    a_hold = station_addr;
    repeat (40) @(negedge clk);
    check(done_cnt == 1, {name, " R9 single done pulse"}, 64'(done_cnt), 64'd1);
    check(image_valid == v_hold && station_addr == a_hold, {name, " R9 result held"},
          64'(station_addr), 64'(a_hold));
    check(log_n == ACCESSES, {name, " R6 access count"}, 64'(log_n), 64'(ACCESSES));
    order_err = 0;
    mis_err = 0;
    for (int k = 0; k < log_n && k < 128; k++) begin
      if (log_addr[k] != ((k == 0) ? 0 : k - 1)) order_err++;
      if (log_mis[k] != (aw == 8 && k == 0)) mis_err++;
    end
    check(order_err == 0, {name, " R6 word order"}, 64'(order_err), 64'd0);
    check(mis_err == 0, {name, " R5 address width choice"}, 64'(mis_err), 64'd0);
    check(opcode_err == 0, {name, " R3 read opcode"}, 64'(opcode_err), 64'd0);
    check(sk_err == 0 && si_err == 0, {name, " R3 half-period and data timing"},
          64'(sk_err + si_err), 64'd0);
    check(cs_err == 0, {name, " R2 select framing"}, 64'(cs_err), 64'd0);
  endtask

  task automatic run_load(input string name, input int aw, input int mul, input int add,
                          input bit good, input bit busy_start);
    fill(aw, mul, add, good);
    clear_logs();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(image_valid == 1'b0 && station_addr == 48'h0, {name, " R9 start clears result"},
          64'(station_addr), 64'd0);
    if (busy_start) begin
      repeat (3000) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    finish_load(name, aw, good);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    fill(6, 16'h1357, 16'h0102, 1'b1);
    log_n = 0; opcode_err = 0;
    repeat (5) @(negedge clk);
    check(!rom_cs && !rom_sck && !image_valid && !load_done && station_addr == 48'h0,
          "R9 R2 reset state", {rom_cs, rom_sck, image_valid, load_done}, 64'd0);
    rst_n = 1'b1;
    finish_load("boot6", 6, 1'b1);                         // R1 automatic load
    run_load("bad6", 6, 16'h1357, 16'h0102, 1'b0, 1'b0);
    run_load("good8", 8, 16'h2a4d, 16'h3c01, 1'b1, 1'b0);
    run_load("bad8", 8, 16'h0f0f, 16'h7777, 1'b0, 1'b0);
    run_load("edge6", 6, 16'h0311, 16'hFFFE, 1'b1, 1'b0);  // R5 boundary 0xFFFE
    run_load("busy8", 8, 16'h4e21, 16'h1200, 1'b1, 1'b1);  // R1 start while busy
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule